// File: doc/BRIEF.md
# Prescaled Module Clock Generator

This block produces a divided clock for a peripheral from one of four parent clocks. All four parents are modelled as per-cycle enable strobes on one system clock, so the whole block is synchronous and its output `clk_out` is a one-cycle strobe in the system clock domain. One 32-bit control word sets four things: which parent drives the block, a power-of-two prescale, an integer divide of m+1, and an output enable.

The selected parent strobe feeds a prescale counter. Each time that counter wraps it produces a prescaled tick, and that tick feeds a divide counter. When the divide counter wraps, and the block is enabled, `clk_out` is high. That gives an output rate of (parent rate >> p) / (m + 1). A two-state machine controls the counters. In OFF they are held at zero and the output is low. In RUN they count. The transition OFF->RUN (named START) is taken at the edge after the enable bit is found set. The transition RUN->OFF (named STOP) is taken at the edge after it is found clear. In both states the machine stays put when the enable bit has not changed.

Top module: `modclk_gen`

## Requirements
- R1: With the selected parent strobe high every cycle, `clk_out` pulses exactly once every D = (m+1)<<p cycles. When the parent strobe has gaps, a pulse comes on every D-th parent strobe instead.
- R2: The divide field m is held in control bits [3:0].
- R3: The prescale field p is held in control bits [17:16].
- R4: The parent select field is held in control bits [25:24]. `clk_out` advances only on `parent_en[sel]`. Strobes on the other parents have no effect.
- R5: Control bit 31 enables the output. Once a write clears it, `clk_out` is low from the cycle right after that write's edge onward.
- R6: `clk_out` is high only in a cycle where the selected parent strobe is also high, so the output is never faster than its parent.
- R7: Reads return the held fields in their positions. All other bits read zero, and writes to them are ignored.
- R8: A register write taken in the RUN state restarts both counters from zero at its edge. The first pulse with the new setting comes in the D-th cycle after that edge.
- R9: With m = 0 and p = 0 in RUN, `clk_out` equals the selected parent strobe in every cycle.
- R10: After reset the control word reads zero, the state is OFF and `clk_out` is low.
- R11: If a write sets the enable bit while the block is OFF, counting starts at the next edge (START). With a parent strobe on every cycle, the first pulse is in the D-th cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word, unused bits zero |
| parent_en | input | 4 | Per-cycle strobes of the four parent clocks |
| clk_out | output | 1 | Divided output strobe |

## Verification
A read-back is valid in the cycle right after the write edge. The output strobe is combinational from the counters and the current parent strobe. The bench therefore drives the parent strobes at the falling edge and samples `clk_out` one time step later, in the same cycle. Cycle indices for R11 are counted from the edge after the enabling write, because the state machine takes one edge to reach RUN. Indices for R8 are counted from the write edge itself, because the machine is already in RUN. Before each table vector the bench writes a disabling word, so every vector starts from OFF and the predicted pulse indices D, 2D and 3D line up exactly.

// File: rtl/modclk_pkg.sv
package modclk_pkg;
    localparam int REG_W   = 32;
    localparam int M_W     = 4;
    localparam int P_W     = 2;
    localparam int SEL_W   = 2;
    localparam int NPAR    = 1 << SEL_W;
    localparam int M_LSB   = 0;
    localparam int P_LSB   = 16;
    localparam int SEL_LSB = 24;
    localparam int EN_BIT  = 31;
    localparam int PC_W    = (1 << P_W) - 1;

    localparam logic [REG_W-1:0] RW_MASK =
        (REG_W'((1 << M_W) - 1) << M_LSB) |
        (REG_W'((1 << P_W) - 1) << P_LSB) |
        (REG_W'((1 << SEL_W) - 1) << SEL_LSB) |
        (REG_W'(1) << EN_BIT);

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [P_W-1:0]   p;
        logic [M_W-1:0]   m;
    } cfg_t;

    typedef enum logic {ST_OFF, ST_RUN} state_e;
endpackage

// File: rtl/modclk_regs.sv
module modclk_regs
    import modclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output cfg_t             cfg,
    output logic [REG_W-1:0] rd_data
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.m   <= wr_data[M_LSB +: M_W];
            cfg_q.p   <= wr_data[P_LSB +: P_W];
            cfg_q.sel <= wr_data[SEL_LSB +: SEL_W];
            cfg_q.en  <= wr_data[EN_BIT];
        end
    end

    always_comb begin
        rd_data                     = '0;
        rd_data[M_LSB +: M_W]       = cfg_q.m;
        rd_data[P_LSB +: P_W]       = cfg_q.p;
        rd_data[SEL_LSB +: SEL_W]   = cfg_q.sel;
        rd_data[EN_BIT]             = cfg_q.en;
    end

    assign cfg = cfg_q;

    // R7: read-back equals the last write with unused bits dropped
    assert_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == ($past(wr_data) & RW_MASK));
endmodule

// File: rtl/modclk_prescaler.sv
module modclk_prescaler
    import modclk_pkg::*;
#(
    parameter int PW = P_W,
    localparam int CW = (1 << PW) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          pe,
    input  logic [PW-1:0] p,
    output logic          tick,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim  = ~({CW{1'b1}} << p);
        tick = pe && (cnt_q == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (pe) begin
            cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R3: prescale count never passes 2^p - 1
    assert_presc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);
endmodule

// File: rtl/modclk_divider.sv
module modclk_divider
    import modclk_pkg::*;
#(
    parameter int MW = M_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [MW-1:0] m,
    output logic          wrap,
    output logic [MW-1:0] cnt_o
);
    logic [MW-1:0] cnt_q;

    assign wrap = tick && (cnt_q == m);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == m) ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R2: divide count never passes m
    assert_div_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= m);
endmodule

// File: rtl/modclk_gen.sv
module modclk_gen
    import modclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [NPAR-1:0]  parent_en,
    output logic             clk_out
);
    cfg_t          cfg;
    state_e        state_q, state_d;
    logic          pe, hold, tick, div_wrap;
    logic [PC_W-1:0] pre_cnt;
    logic [M_W-1:0]  div_cnt;

    modclk_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg(cfg), .rd_data(rd_data)
    );

    assign pe = parent_en[cfg.sel];

    modclk_prescaler #(.PW(P_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(hold), .pe(pe), .p(cfg.p),
        .tick(tick), .cnt_o(pre_cnt)
    );

    modclk_divider #(.MW(M_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clear(hold), .tick(tick), .m(cfg.m),
        .wrap(div_wrap), .cnt_o(div_cnt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state: START and STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (cfg.en)  state_d = ST_RUN;
            ST_RUN: if (!cfg.en) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // outputs per state
    always_comb begin
        hold    = 1'b1;
        clk_out = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                hold    = 1'b1;
                clk_out = 1'b0;
            end
            ST_RUN: begin
                hold    = wr_en;
                clk_out = cfg.en && div_wrap;
            end
            default: begin
                hold    = 1'b1;
                clk_out = 1'b0;
            end
        endcase
    end

    // R6: no output pulse without the selected parent strobe
    assert_out_needs_parent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out |-> parent_en[cfg.sel]);

    // R8: a write leaves both counters at zero
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pre_cnt == '0) && (div_cnt == '0));

    // R5: a disabling write silences the output from the next cycle
    assert_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[EN_BIT]) |=> !clk_out);

    // R9: undivided setting passes the parent strobe straight through
    assert_direct_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cfg.en && cfg.m == '0 && cfg.p == '0) |-> clk_out == pe);
endmodule

// File: tb/modclk_gen_tb.sv
module modclk_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  parent_en = '0;
    logic        clk_out;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    modclk_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .parent_en(parent_en), .clk_out(clk_out)
    );

    // {sel[2], p[2], m[4], period[8]}
    localparam logic [15:0] VEC [6] = '{
        {2'd0, 2'd0, 4'd0,  8'd1},
        {2'd0, 2'd0, 4'd3,  8'd4},
        {2'd1, 2'd1, 4'd2,  8'd6},
        {2'd2, 2'd2, 4'd4,  8'd20},
        {2'd3, 2'd3, 4'd15, 8'd128},
        {2'd1, 2'd0, 4'd9,  8'd10}
    };

    function automatic logic [31:0] word(input bit en, input int sel, input int p, input int m);
        return {en, 5'd0, 2'(sel), 6'd0, 2'(p), 12'd0, 4'(m)};
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int first, cnt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset read", rd_data, 0);
        check("R10 reset output", clk_out, 0);

        // R7: read-back with unused bits dropped
        write(32'hFFFF_FFFF);
        @(negedge clk);
        check("R7 readback", rd_data, 32'h8303_000F);
        write(32'h0);

        // R1 R2 R3 R4 R11: table walk
        foreach (VEC[k]) begin
            int sel, p, m, per;
            sel = VEC[k][15:14]; p = VEC[k][13:12]; m = VEC[k][11:8]; per = VEC[k][7:0];
            write(32'h0);
            parent_en = 4'(1 << sel);
            write(word(1, sel, p, m));
            @(posedge clk);
            first = 0; cnt = 0;
            for (int i = 1; i <= 3 * per; i++) begin
                @(negedge clk); #1;
                if (clk_out) begin
                    cnt++;
                    if (first == 0) first = i;
                end
            end
            check("R11 R2 R3 R4 first pulse index", first, per);
            check("R1 pulse count over 3 periods", cnt, 3);
        end

        // R4: other parents toggle, selected parent silent
        write(32'h0);
        parent_en = 4'b0111;
        write(word(1, 3, 0, 0));
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); parent_en = {1'b0, 3'(i)}; #1;
            if (clk_out) cnt++;
        end
        check("R4 unselected parents ignored", cnt, 0);

        // R1 gapped parent: m=1 p=1 -> pulse on every 4th parent strobe
        write(32'h0);
        parent_en = '0;
        write(word(1, 2, 1, 1));
        @(posedge clk);
        first = 0; cnt = 0;
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk); parent_en = (i % 2 == 1) ? 4'b0100 : 4'b0000; #1;
            if (clk_out) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
        check("R1 gapped first pulse", first, 7);
        check("R1 gapped pulse count", cnt, 2);

        // R9 R6: pass-through with m=0 p=0
        write(32'h0);
        parent_en = '0;
        write(word(1, 2, 0, 0));
        @(posedge clk);
        cnt = 0;
        for (int i = 0; i < 24; i++) begin
            logic b;
            b = ((i * 7) % 5) < 2;
            @(negedge clk); parent_en = {~b, b, ~b, ~b}; #1;
            if (clk_out != b) cnt++;
        end
        check("R9 R6 output follows parent", cnt, 0);

        // R5: disable while parent runs
        parent_en = 4'b1111;
        write(word(0, 2, 0, 0));
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            if (clk_out) cnt++;
        end
        check("R5 output low after disable", cnt, 0);

        // R8: restart on write while running
        write(32'h0);
        parent_en = 4'b0001;
        write(word(1, 0, 0, 3));
        @(posedge clk);
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_data = word(1, 0, 0, 1);
        @(posedge clk);
        #1 wr_en = 1'b0;
        first = 0; cnt = 0;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk); #1;
            if (clk_out) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
        check("R8 first pulse after rewrite", first, 2);
        check("R8 pulses after rewrite", cnt, 2);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule